// File: doc/BRIEF.md
# ECC Read-Merge-Write Sequencer

This block sits in front of a word-wide memory that keeps 32 data bits together with a 7-bit single-error-correcting, double-error-detecting check code. Requesters see a 32-bit read/write port with four byte enables. Reads are checked and corrected on the way back. A write that covers the whole word is sent straight to memory with a newly computed code. A write that covers only some bytes must first fetch the stored word. The block checks and corrects that word, overlays the new bytes, recomputes the code and stores the result.

A write-protect flag that comes with each request makes the block drop the write. The requester still gets a completion, but memory sees no traffic. Memory timing is reduced to a request/acknowledge handshake. Errors found while reading raise one-cycle interrupt pulses: one for corrected single-bit faults and one for uncorrectable double-bit faults. The block accepts one request at a time.

Top module: `ecc_rmw_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block shows `req_ready` high and `mem_req`, `rsp_valid`, `irq_corr` and `irq_uncorr` low.
- R2: `req_ready` is high only when the block is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. A taken request that needs memory holds `req_ready` low until its completion.
- R3: A write with all four byte enables set (enable bit i selects data bits 8i+7..8i) is issued as exactly one memory write with no read. The stored contents are not checked, so no interrupt fires even if the stored word is corrupt.
- R4: A write with fewer than four byte enables set (including none) issues exactly one memory read, followed by exactly one memory write to the same address.
- R5: The word written back by a partial write takes the enabled bytes from the request and every other byte from the word that was read. The read word is corrected first if it holds a single-bit error.
- R6: A single flipped bit anywhere in the 39 stored bits, found by a read phase, raises `irq_corr` for exactly one cycle, and the corrected data is used.
- R7: Two flipped bits found by a read phase raise `irq_uncorr` for one cycle. The data is used uncorrected, and a partial write still completes its write-back.
- R8: A write whose `req_wprot` is high, whether partial or full, causes no memory access and leaves the stored word unchanged. It completes with `rsp_valid` one cycle after it is taken.
- R9: A read issues exactly one memory read and returns the checked data on `rsp_rdata` while `rsp_valid` is high.
- R10: Once raised, `mem_req` stays high, with `mem_we`, `mem_addr` and `mem_wdata` stable, until the cycle in which `mem_ack` is seen.
- R11: A word stored by the block, by either a full or a partial write, reads back later with no interrupt.
- R12: Each taken request gives exactly one single-cycle `rsp_valid` pulse, and `req_ready` is high again in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for data byte i |
| req_wprot | input | 1 | Target is write-protected |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Checked read data, valid with `rsp_valid` on reads |
| irq_corr | output | 1 | Pulse: corrected single-bit error |
| irq_uncorr | output | 1 | Pulse: uncorrectable error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_wcheck | output | 7 | Memory write check code |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data |
| mem_rcheck | input | 7 | Memory read check code |

## Verification
The bench corrupts stored words before full writes. A design that checked old contents on a full write would raise interrupts there, and one that read first would show up in the count of memory operations. It flips single data, check and overall-parity bits before partial writes and reads. A design that merged uncorrected data, or that mis-placed the syndrome, would store or return a wrong word. It applies double flips before a partial write. A design that dropped the write-back, or that tried to correct the word, would leave a stored word different from the raw-merge result. Protected partial and full writes and a zero-enable write are also applied. The first must leave memory untouched, and the last must still perform a clean read-and-rewrite.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DW   = 32;          // data bits per word
  localparam int NB   = DW / 8;      // byte lanes
  localparam int HW   = 6;           // Hamming check bits
  localparam int CW   = HW + 1;      // plus overall parity
  localparam int PMAX = DW + HW;     // highest codeword position

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_st_e;

  // Codeword position of data bit k: k-th non-power-of-two from 3 up.
  function automatic logic [HW-1:0] data_pos(input int k);
    int cnt;
    logic [HW-1:0] r;
    cnt = 0;
    r   = '0;
    for (int p = 3; p <= PMAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) r = HW'(p);
        cnt++;
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] ecc_gen(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic [HW-1:0] pos;
    c = '0;
    for (int k = 0; k < DW; k++) begin
      pos = data_pos(k);
      for (int i = 0; i < HW; i++) begin
        if (pos[i]) c[i] = c[i] ^ d[k];
      end
    end
    c[HW] = (^d) ^ (^c[HW-1:0]);
    return c;
  endfunction

  function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) begin
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] check
);
  always_comb begin
    check = ecc_gen(data);
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_rmw_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] check,
  output logic [DW-1:0] data_fix,
  output logic          err_corr,
  output logic          err_uncorr
);
  logic [CW-1:0] recalc;
  logic [HW-1:0] syn;
  logic          par;

  always_comb begin
    recalc = ecc_gen(data);
    syn    = check[HW-1:0] ^ recalc[HW-1:0];
    par    = (^data) ^ (^check);
  end

  // Odd overall parity: one flipped bit, located by the syndrome.
  always_comb begin
    data_fix = data;
    for (int k = 0; k < DW; k++) begin
      if (par && (syn == data_pos(k))) data_fix[k] = ~data[k];
    end
  end

  assign err_corr   = par;
  assign err_uncorr = !par && (syn != '0);
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_rmw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NB-1:0] req_be,
  input  logic          req_wprot,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          irq_corr,
  output logic          irq_uncorr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] dec_data,
  input  logic          dec_corr,
  input  logic          dec_uncorr
);
  seq_st_e       st_q, st_d;
  logic          rsp_q, rsp_d;
  logic          irqc_q, irqc_d;
  logic          irqu_q, irqu_d;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] buf_q, buf_d;
  logic          buf_en, req_en;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    rsp_d  = 1'b0;
    irqc_d = 1'b0;
    irqu_d = 1'b0;
    buf_d  = req_wdata;
    buf_en = 1'b0;
    req_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_en = 1'b1;
          buf_en = 1'b1;
          if (req_write && req_wprot) rsp_d = 1'b1;       // discarded
          else if (req_write && (&req_be)) st_d = ST_WR;  // direct store
          else st_d = ST_RD;                              // read or merge
        end
      end
      ST_RD: begin
        if (mem_ack) begin
          irqc_d = dec_corr;
          irqu_d = dec_uncorr;
          buf_en = 1'b1;
          if (wr_q) begin
            buf_d = byte_merge(dec_data, buf_q, be_q);
            st_d  = ST_WR;
          end else begin
            buf_d = dec_data;
            rsp_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          rsp_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rsp_q  <= 1'b0;
      irqc_q <= 1'b0;
      irqu_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rsp_q  <= rsp_d;
      irqc_q <= irqc_d;
      irqu_q <= irqu_d;
    end
  end

  // Datapath registers, clock-enabled, not reset
  always_ff @(posedge clk) begin
    if (req_en) begin
      addr_q <= req_addr;
      wr_q   <= req_write;
      be_q   <= req_be;
    end
    if (buf_en) buf_q <= buf_d;
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = buf_q;
  assign irq_corr   = irqc_q;
  assign irq_uncorr = irqu_q;
  assign mem_req    = (st_q != ST_IDLE);
  assign mem_we     = (st_q == ST_WR);
  assign mem_addr   = addr_q;
  assign mem_wdata  = buf_q;

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r3_full_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> !(wr_q && (&be_q)));

  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && wr_q) |=> (mem_req && mem_we));

  a_r8_protected_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_wprot) |=> !mem_req);

  a_r6_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_corr && irq_uncorr));

  a_r7_irq_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_corr || irq_uncorr) |-> $past(mem_req && !mem_we && mem_ack));
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_rmw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic [3:0]    req_be,
  input  logic          req_wprot,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          irq_corr,
  output logic          irq_uncorr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [6:0]    mem_wcheck,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic [6:0]    mem_rcheck
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [DW-1:0] dec_data;
  logic          dec_corr, dec_uncorr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ecc_dec u_dec (
    .data       (mem_rdata),
    .check      (mem_rcheck),
    .data_fix   (dec_data),
    .err_corr   (dec_corr),
    .err_uncorr (dec_uncorr)
  );

  ecc_enc u_enc (
    .data  (mem_wdata),
    .check (mem_wcheck)
  );

  ecc_rmw_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .req_wprot  (req_wprot),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .irq_corr   (irq_corr),
    .irq_uncorr (irq_uncorr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .dec_data   (dec_data),
    .dec_corr   (dec_corr),
    .dec_uncorr (dec_uncorr)
  );
endmodule

// File: tb/tb_ecc_rmw_seq.sv
`timescale 1ns/1ps
module tb_ecc_rmw_seq;
  localparam int AW = 3;
  localparam int NW = 8;
  localparam int NV = 23;

  // {addr[2:0], write, be[3:0], prot, nflip[1:0], flip0[5:0], flip1[5:0], wdata[31:0]}
  localparam logic [54:0] VECS [NV] = '{
    {3'd0, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd1, 1'b0, 4'h0, 1'b0, 2'd1, 6'd5,  6'd0,  32'h0},
    {3'd2, 1'b0, 4'h0, 1'b0, 2'd2, 6'd3,  6'd20, 32'h0},
    {3'd3, 1'b0, 4'h0, 1'b0, 2'd1, 6'd34, 6'd0,  32'h0},
    {3'd3, 1'b0, 4'h0, 1'b0, 2'd1, 6'd38, 6'd0,  32'h0},
    {3'd4, 1'b1, 4'hF, 1'b0, 2'd0, 6'd0,  6'd0,  32'h12345678},
    {3'd5, 1'b1, 4'hF, 1'b0, 2'd2, 6'd0,  6'd31, 32'hCAFEF00D},
    {3'd6, 1'b1, 4'h1, 1'b0, 2'd0, 6'd0,  6'd0,  32'h000000EE},
    {3'd7, 1'b1, 4'hA, 1'b0, 2'd1, 6'd10, 6'd0,  32'h11223344},
    {3'd0, 1'b1, 4'h6, 1'b0, 2'd2, 6'd1,  6'd33, 32'h99887766},
    {3'd1, 1'b1, 4'h3, 1'b1, 2'd0, 6'd0,  6'd0,  32'hDEADBEEF},
    {3'd2, 1'b1, 4'hF, 1'b1, 2'd0, 6'd0,  6'd0,  32'h01020304},
    {3'd6, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd7, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd4, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd3, 1'b1, 4'h0, 1'b0, 2'd1, 6'd7,  6'd0,  32'hFFFFFFFF},
    {3'd3, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd5, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd0, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd1, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd2, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0},
    {3'd5, 1'b1, 4'hC, 1'b0, 2'd1, 6'd36, 6'd0,  32'hABCD0000},
    {3'd5, 1'b0, 4'h0, 1'b0, 2'd0, 6'd0,  6'd0,  32'h0}
  };

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write, req_wprot;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic [3:0]    req_be;
  logic          rsp_valid, irq_corr, irq_uncorr;
  logic [31:0]   rsp_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [6:0]    mem_wcheck, mem_rcheck;

  logic [31:0] md [NW];
  logic [6:0]  mc [NW];
  logic [31:0] golden [NW];
  int          n_rd, n_wr;
  logic [1:0]  op_log;   // first two ops: bit0 = first op we, bit1 = second op we
  int          n_chk, n_err;

  ecc_rmw_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_wprot(req_wprot),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_corr(irq_corr), .irq_uncorr(irq_uncorr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wcheck(mem_wcheck),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rcheck(mem_rcheck)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // Memory model: acknowledges each request one cycle after it appears.
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; mem_rcheck = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req === 1'b1) begin
        mem_ack = 1'b1;
        if ((n_rd + n_wr) < 2) op_log[n_rd + n_wr] = mem_we;
        if (mem_we) begin
          md[mem_addr] = mem_wdata;
          mc[mem_addr] = mem_wcheck;
          n_wr++;
        end else begin
          mem_rdata  = md[mem_addr];
          mem_rcheck = mc[mem_addr];
          n_rd++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish");
    n_err++;
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] merge_ref(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // Issue one request and wait for its completion.
  task automatic run_op(input logic [AW-1:0] a, input logic wr, input logic [3:0] be,
                        input logic [31:0] wd, input logic prot,
                        output int gc, output int gu, output logic [31:0] grd);
    bit done;
    @(negedge clk);
    n_rd = 0; n_wr = 0; op_log = 2'b00;
    req_addr = a; req_write = wr; req_be = be; req_wdata = wd; req_wprot = prot;
    req_valid = 1'b1;
    check("R2 ready before issue", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && prot) check("R8 immediate completion", {63'd0, rsp_valid}, 64'd1);
    else            check("R2 busy after accept", {63'd0, req_ready}, 64'd0);
    gc = 0; gu = 0; grd = '0; done = 0;
    for (int c = 0; c < 60 && !done; c++) begin
      if (irq_corr)   gc++;
      if (irq_uncorr) gu++;
      if (rsp_valid) begin
        done = 1;
        grd  = rsp_rdata;
        check("R12 ready with completion", {63'd0, req_ready}, 64'd1);
      end else @(negedge clk);
    end
    if (!done) check("R12 completion timeout", 64'd0, 64'd1);
    @(negedge clk);
    check("R12 single-cycle completion", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    int gc, gu;
    logic [31:0] grd;
    n_chk = 0; n_err = 0; n_rd = 0; n_wr = 0; op_log = 2'b00;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    req_be = '0; req_wprot = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset ready", {63'd0, req_ready}, 64'd1);
    check("R1 reset outputs", {60'd0, mem_req, rsp_valid, irq_corr, irq_uncorr}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {59'd0, req_ready, mem_req, rsp_valid, irq_corr, irq_uncorr}, 64'h10);

    // Fill memory with full writes (R3)
    for (int a = 0; a < NW; a++) begin
      golden[a] = 32'h5A00_0000 + a * 32'h0011_2233;
      run_op(AW'(a), 1'b1, 4'hF, golden[a], 1'b0, gc, gu, grd);
      check("R3 init op counts", {32'(n_rd), 32'(n_wr)}, {32'd0, 32'd1});
      check("R3 init stored data", {32'd0, md[a]}, {32'd0, golden[a]});
    end

    // Table-driven pass
    for (int i = 0; i < NV; i++) begin
      logic [54:0]   v;
      logic [AW-1:0] a;
      logic          wr, prot, executes, reads;
      logic [3:0]    be;
      logic [1:0]    nf;
      logic [5:0]    f0, f1;
      logic [31:0]   wd, pd, raw, base, exp_st;
      logic [6:0]    pc;
      int            exp_rd, exp_wr;
      string         itag;
      v = VECS[i];
      a = v[54:52]; wr = v[51]; be = v[50:47]; prot = v[46]; nf = v[45:44];
      f0 = v[43:38]; f1 = v[37:32]; wd = v[31:0];
      pd = md[a]; pc = mc[a];
      if (nf >= 2'd1) begin
        if (f0 < 6'd32) md[a][f0] = ~md[a][f0]; else mc[a][f0 - 6'd32] = ~mc[a][f0 - 6'd32];
      end
      if (nf == 2'd2) begin
        if (f1 < 6'd32) md[a][f1] = ~md[a][f1]; else mc[a][f1 - 6'd32] = ~mc[a][f1 - 6'd32];
      end
      raw      = md[a];
      base     = (nf == 2'd2) ? raw : golden[a];
      executes = !(wr && prot);
      reads    = !wr || (executes && (be != 4'hF));
      exp_rd   = reads ? 1 : 0;
      exp_wr   = (wr && executes) ? 1 : 0;
      exp_st   = merge_ref(base, wd, be);
      run_op(a, wr, be, wd, prot, gc, gu, grd);
      itag = (nf == 2'd0) ? "R11 no irq on clean word" : (nf == 2'd1) ? "R6 irq pattern" : "R7 irq pattern";
      if (!reads) itag = "R3 no check without read";
      check(itag, {32'(gc), 32'(gu)},
            {32'((reads && nf == 2'd1) ? 1 : 0), 32'((reads && nf == 2'd2) ? 1 : 0)});
      if (!wr) begin
        check("R9 read op counts", {32'(n_rd), 32'(n_wr)}, {32'd1, 32'd0});
        check(nf == 2'd2 ? "R7 raw read data" : "R9 read data", {32'd0, grd}, {32'd0, base});
        md[a] = pd; mc[a] = pc;
      end else if (prot) begin
        check("R8 no memory access", {32'(n_rd), 32'(n_wr)}, {32'd0, 32'd0});
        check("R8 stored word unchanged", {25'd0, mc[a], md[a]}, {25'd0, pc ^ pc ^ mc[a], raw});
        md[a] = pd; mc[a] = pc;
      end else if (be == 4'hF) begin
        check("R3 full write op counts", {32'(n_rd), 32'(n_wr)}, {32'd0, 32'd1});
        check("R3 full write data", {32'd0, md[a]}, {32'd0, wd});
        golden[a] = wd;
      end else begin
        check("R4 partial op counts", {32'(n_rd), 32'(n_wr)}, {32'd1, 32'd1});
        check("R4 read before write", {62'd0, op_log}, 64'd2);
        check(nf == 2'd2 ? "R7 merge of raw word" : "R5 merged data", {32'd0, md[a]}, {32'd0, exp_st});
        golden[a] = exp_st;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule